// File: doc/BRIEF.md
# Packed Dot-Product Accumulate Unit

This unit takes three packed vectors of 32-bit lanes: an accumulator vector and two source vectors. In every lane it multiplies the narrow elements of the two sources pairwise, sums those products with the accumulator lane, and writes the lane result under a per-lane enable. Lanes whose enable is clear either pass the accumulator lane through unchanged or are forced to zero, as chosen by a separate input.

Two element sizes are supported. With byte elements, each lane multiplies four unsigned bytes of the first source by four signed bytes of the second. With 16-bit elements, each lane multiplies two pairs of signed words. Either size can wrap modulo 2^32 or clamp to the signed 32-bit range. The number of active lanes is a parameter (4 or 8). The port width is fixed at the maximum, and any lane above the active count reads zero. A single strobe captures one operation, and the result is presented in the following cycle.

Top module: `pdp_accum`

## Requirements
- R1: With op_mode bit 0 clear (byte elements), result lane j equals acc_in lane j plus the sum over k = 0..3 of src_a byte (4j+k), read unsigned, times src_b byte (4j+k), read as signed two's complement. Byte n occupies bits [8n+7:8n], and lane j occupies bits [32j+31:32j].
- R2: With op_mode bit 0 set (word elements), result lane j equals acc_in lane j plus the two products of the signed 16-bit words 2j and 2j+1 of src_a and src_b. Word n occupies bits [16n+15:16n].
- R3: With op_mode bit 1 clear, the lane sum wraps modulo 2^32.
- R4: With op_mode bit 1 set, the exact sum is clamped to the range from -2^31 (0x80000000) to 2^31-1 (0x7FFFFFFF).
- R5: A lane whose lane_en bit is 0 outputs its acc_in lane unchanged when zero_mask is 0.
- R6: A lane whose lane_en bit is 0 outputs 0 when zero_mask is 1. Lanes whose lane_en bit is 1 always carry the computed value.
- R7: Lanes at index LANES and above always output 0, whatever their inputs are.
- R8: out_valid is 1 in the cycle after a clock edge that samples in_valid high, and 0 otherwise. result changes only on an edge that samples in_valid high, and holds its value otherwise.
- R9: A synchronous active-high rst clears out_valid and result to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Captures one operation at this edge |
| op_mode | input | 2 | Bit 0: word elements; bit 1: saturating |
| zero_mask | input | 1 | 1: disabled lanes read zero; 0: disabled lanes keep acc_in |
| lane_en | input | MAX_LANES | Per-lane write enable |
| acc_in | input | MAX_LANES*32 | Packed accumulator lanes |
| src_a | input | MAX_LANES*32 | First source (unsigned bytes or signed words) |
| src_b | input | MAX_LANES*32 | Second source (signed bytes or signed words) |
| out_valid | output | 1 | Result valid |
| result | output | MAX_LANES*32 | Packed lane results |

## Verification
The mask assertions assume that acc_in, lane_en and zero_mask are stable across the capturing edge, because they compare the lane output with the previous cycle's inputs. The bench therefore changes every input only at the falling edge. It drives in_valid for exactly one cycle per operation, and it never raises reset while an assertion window is open, except in the dedicated reset scenario. The clamping checks rely on the arithmetic operands being within their stated widths. The bench reaches the extremes only with full-scale byte and word patterns, so no product can exceed its lane range.

// File: rtl/pdp_pkg.sv
package pdp_pkg;
    localparam int unsigned LANE_W  = 32;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned WORD_W  = 16;
    localparam int unsigned PROD_W  = 2 * WORD_W;
    // four extra bits of headroom over a lane keep every sum exact
    localparam int unsigned SUM_W   = LANE_W + 4;
    localparam int unsigned OPB_WORD = 0;
    localparam int unsigned OPB_SAT  = 1;
endpackage

// File: rtl/pdp_lane_mul.sv
module pdp_lane_mul #(
    parameter int unsigned LANE_W = 32,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned WORD_W = 16,
    parameter int unsigned PROD_W = 32,
    localparam int unsigned NTERM = LANE_W / BYTE_W
) (
    input  logic                    word_mode,
    input  logic [LANE_W-1:0]       a_lane,
    input  logic [LANE_W-1:0]       b_lane,
    output logic [NTERM*PROD_W-1:0] terms
);
    localparam int unsigned NWORD = LANE_W / WORD_W;
    localparam int unsigned BP_W  = 2 * BYTE_W + 2;

    for (genvar k = 0; k < NTERM; k++) begin : g_term
        logic [BP_W-1:0]   u_ext;
        logic [BP_W-1:0]   s_ext;
        logic [BP_W-1:0]   b_prod;
        logic [PROD_W-1:0] b_term;

        // unsigned times signed: operands widened so the low bits are exact
        assign u_ext  = {{(BP_W-BYTE_W){1'b0}}, a_lane[k*BYTE_W +: BYTE_W]};
        assign s_ext  = {{(BP_W-BYTE_W){b_lane[k*BYTE_W+BYTE_W-1]}},
                         b_lane[k*BYTE_W +: BYTE_W]};
        assign b_prod = u_ext * s_ext;
        assign b_term = {{(PROD_W-BP_W){b_prod[BP_W-1]}}, b_prod};

        if (k < NWORD) begin : g_word
            logic [PROD_W-1:0] wa;
            logic [PROD_W-1:0] wb;
            logic [PROD_W-1:0] w_prod;
            assign wa = {{(PROD_W-WORD_W){a_lane[k*WORD_W+WORD_W-1]}},
                         a_lane[k*WORD_W +: WORD_W]};
            assign wb = {{(PROD_W-WORD_W){b_lane[k*WORD_W+WORD_W-1]}},
                         b_lane[k*WORD_W +: WORD_W]};
            assign w_prod = wa * wb;
            assign terms[k*PROD_W +: PROD_W] = word_mode ? w_prod : b_term;
        end else begin : g_noword
            assign terms[k*PROD_W +: PROD_W] = word_mode ? '0 : b_term;
        end
    end
endmodule

// File: rtl/pdp_lane_sum.sv
module pdp_lane_sum #(
    parameter int unsigned LANE_W = 32,
    parameter int unsigned PROD_W = 32,
    parameter int unsigned NTERM  = 4,
    parameter int unsigned SUM_W  = 36
) (
    input  logic                    sat_mode,
    input  logic                    zero_mask,
    input  logic                    lane_en,
    input  logic [LANE_W-1:0]       acc,
    input  logic [NTERM*PROD_W-1:0] terms,
    output logic [LANE_W-1:0]       lane_out
);
    localparam int unsigned HI_W = SUM_W - LANE_W + 1;

    logic [SUM_W-1:0]  total;
    logic [HI_W-1:0]   hi;
    logic              pos_ovf;
    logic              neg_ovf;
    logic [LANE_W-1:0] val;

    always_comb begin
        total = {{(SUM_W-LANE_W){acc[LANE_W-1]}}, acc};
        for (int k = 0; k < NTERM; k++) begin
            total = total + {{(SUM_W-PROD_W){terms[k*PROD_W+PROD_W-1]}},
                             terms[k*PROD_W +: PROD_W]};
        end
        // the bits above the lane sign must all equal the sum's sign
        hi      = total[SUM_W-1:LANE_W-1];
        pos_ovf = !total[SUM_W-1] && (|hi);
        neg_ovf = total[SUM_W-1] && !(&hi);
        if (sat_mode && pos_ovf)
            val = {1'b0, {(LANE_W-1){1'b1}}};
        else if (sat_mode && neg_ovf)
            val = {1'b1, {(LANE_W-1){1'b0}}};
        else
            val = total[LANE_W-1:0];
        if (lane_en)
            lane_out = val;
        else if (zero_mask)
            lane_out = '0;
        else
            lane_out = acc;
    end
endmodule

// File: rtl/pdp_accum.sv
module pdp_accum
    import pdp_pkg::*;
#(
    parameter int unsigned MAX_LANES = 8,
    parameter int unsigned LANES     = 8,
    localparam int unsigned VEC_W    = MAX_LANES * LANE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [1:0]           op_mode,
    input  logic                 zero_mask,
    input  logic [MAX_LANES-1:0] lane_en,
    input  logic [VEC_W-1:0]     acc_in,
    input  logic [VEC_W-1:0]     src_a,
    input  logic [VEC_W-1:0]     src_b,
    output logic                 out_valid,
    output logic [VEC_W-1:0]     result
);
    localparam int unsigned NTERM = LANE_W / BYTE_W;

    typedef struct packed {
        logic             vld;
        logic [VEC_W-1:0] data;
    } stage_t;

    stage_t           st_d;
    stage_t           st_q;
    logic [VEC_W-1:0] lane_vals;

    for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
        if (j < LANES) begin : g_act
            logic [NTERM*PROD_W-1:0] terms;

            pdp_lane_mul #(
                .LANE_W(LANE_W), .BYTE_W(BYTE_W),
                .WORD_W(WORD_W), .PROD_W(PROD_W)
            ) u_mul (
                .word_mode(op_mode[OPB_WORD]),
                .a_lane   (src_a[j*LANE_W +: LANE_W]),
                .b_lane   (src_b[j*LANE_W +: LANE_W]),
                .terms    (terms)
            );

            pdp_lane_sum #(
                .LANE_W(LANE_W), .PROD_W(PROD_W),
                .NTERM(NTERM), .SUM_W(SUM_W)
            ) u_sum (
                .sat_mode (op_mode[OPB_SAT]),
                .zero_mask(zero_mask),
                .lane_en  (lane_en[j]),
                .acc      (acc_in[j*LANE_W +: LANE_W]),
                .terms    (terms),
                .lane_out (lane_vals[j*LANE_W +: LANE_W])
            );
        end else begin : g_idle
            assign lane_vals[j*LANE_W +: LANE_W] = '0;
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid)
            st_d.data = lane_vals;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.data;
endmodule

// File: rtl/pdp_accum_chk.sv
module pdp_accum_chk #(
    parameter int unsigned MAX_LANES = 8,
    parameter int unsigned LANES     = 8,
    parameter int unsigned LW        = 32
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    zero_mask,
    input logic [MAX_LANES-1:0]    lane_en,
    input logic [MAX_LANES*LW-1:0] acc_in,
    input logic                    out_valid,
    input logic [MAX_LANES*LW-1:0] result
);
    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R8
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    for (genvar j = 0; j < MAX_LANES; j++) begin : g_chk
        if (j < LANES) begin : g_act
            // R5
            merge_keep_chk: assert property (@(posedge clk) disable iff (rst)
                (in_valid && !zero_mask && !lane_en[j]) |=>
                (result[j*LW +: LW] == $past(acc_in[j*LW +: LW])));

            // R6
            zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
                (in_valid && zero_mask && !lane_en[j]) |=>
                (result[j*LW +: LW] == '0));
        end else begin : g_idle
            // R7
            upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
                result[j*LW +: LW] == '0);
        end
    end
endmodule

bind pdp_accum pdp_accum_chk #(
    .MAX_LANES(MAX_LANES), .LANES(LANES), .LW(32)
) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .zero_mask(zero_mask),
    .lane_en(lane_en), .acc_in(acc_in), .out_valid(out_valid), .result(result)
);

// File: tb/pdp_accum_test.sv
module pdp_accum_test;
    localparam int NL = 8;
    localparam int VW = NL * 32;
    localparam longint SMAX = 64'sh7FFF_FFFF;
    localparam longint SMIN = -64'sh8000_0000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [1:0]    op_mode = 2'b00;
    logic          zero_mask = 1'b0;
    logic [NL-1:0] lane_en = '0;
    logic [VW-1:0] acc_in = '0;
    logic [VW-1:0] src_a = '0;
    logic [VW-1:0] src_b = '0;
    logic          ov_full, ov_half;
    logic [VW-1:0] res_full, res_half;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    pdp_accum #(.MAX_LANES(NL), .LANES(8)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_mode(op_mode),
        .zero_mask(zero_mask), .lane_en(lane_en), .acc_in(acc_in),
        .src_a(src_a), .src_b(src_b), .out_valid(ov_full), .result(res_full)
    );

    pdp_accum #(.MAX_LANES(NL), .LANES(4)) uut_half (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_mode(op_mode),
        .zero_mask(zero_mask), .lane_en(lane_en), .acc_in(acc_in),
        .src_a(src_a), .src_b(src_b), .out_valid(ov_half), .result(res_half)
    );

    function automatic logic [31:0] ref_lane(logic [1:0] md, logic zm, logic en,
                                             logic [31:0] s, logic [31:0] a,
                                             logic [31:0] b);
        longint sum, x, y;
        sum = longint'($signed(s));
        if (!md[0]) begin
            for (int k = 0; k < 4; k++) begin
                x = longint'(a[8*k +: 8]);
                y = longint'($signed(b[8*k +: 8]));
                sum += x * y;
            end
        end else begin
            for (int k = 0; k < 2; k++) begin
                x = longint'($signed(a[16*k +: 16]));
                y = longint'($signed(b[16*k +: 16]));
                sum += x * y;
            end
        end
        if (md[1]) begin
            if (sum > SMAX) sum = SMAX;
            else if (sum < SMIN) sum = SMIN;
        end
        if (!en) return zm ? 32'h0 : s;
        return sum[31:0];
    endfunction

    function automatic logic [VW-1:0] exp_vec(int active);
        logic [VW-1:0] v = '0;
        for (int j = 0; j < active; j++)
            v[32*j +: 32] = ref_lane(op_mode, zero_mask, lane_en[j],
                                     acc_in[32*j +: 32], src_a[32*j +: 32],
                                     src_b[32*j +: 32]);
        return v;
    endfunction

    task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_vec(string req, logic [VW-1:0] act, logic [VW-1:0] exp);
        for (int j = 0; j < NL; j++) begin
            n_checks++;
            if (act[32*j +: 32] !== exp[32*j +: 32]) begin
                n_fails++;
                $display("FAIL %s lane %0d: got %h expected %h",
                         req, j, act[32*j +: 32], exp[32*j +: 32]);
            end
        end
    endtask

    // drive one operation, then check both instances one cycle later
    task automatic run_op(string req, logic [1:0] md, logic zm, logic [NL-1:0] en,
                          logic [VW-1:0] s, logic [VW-1:0] a, logic [VW-1:0] b);
        @(negedge clk);
        op_mode = md; zero_mask = zm; lane_en = en;
        acc_in = s; src_a = a; src_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check32({req, " out_valid"}, {31'b0, ov_full}, 32'd1);
        check_vec({req, " full"}, res_full, exp_vec(8));
        check_vec({req, " half"}, res_half, exp_vec(4));
    endtask

    task automatic t_reset;
        @(negedge clk);
        check32("R9 reset out_valid", {31'b0, ov_full}, 32'd0);
        check_vec("R9 reset result", res_full, '0);
        rst = 1'b0;
        run_op("R9 pre", 2'b00, 1'b0, '1, {8{32'd9}}, {32{8'd3}}, {32{8'd2}});
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check32("R9 mid reset out_valid", {31'b0, ov_full}, 32'd0);
        check_vec("R9 mid reset result", res_full, '0);
    endtask

    task automatic t_byte_basic;
        // bytes 1,2,3,4 times 5,-6,7,-8 -> -18, plus 100 = 82
        run_op("R1 byte", 2'b00, 1'b0, '1, {8{32'd100}},
               {8{32'h04030201}}, {8{32'hF807FA05}});
        check32("R1 byte lane0", res_full[31:0], 32'd82);
    endtask

    task automatic t_word_basic;
        // words -3,1000 times 7,-2 -> -2021, plus 5 = -2016
        run_op("R2 word", 2'b01, 1'b0, '1, {8{32'd5}},
               {8{32'h03E8FFFD}}, {8{32'hFFFE0007}});
        check32("R2 word lane0", res_full[31:0], 32'hFFFF_F820);
    endtask

    task automatic t_wrap;
        run_op("R3 byte wrap", 2'b00, 1'b0, '1, {8{32'h8000_0000}},
               {32{8'hFF}}, {32{8'h80}});
        check32("R3 byte wrap lane0", res_full[31:0], 32'h7FFE_0200);
        run_op("R3 word wrap", 2'b01, 1'b0, '1, '0,
               {16{16'h8000}}, {16{16'h8000}});
        check32("R3 word wrap lane0", res_full[31:0], 32'h8000_0000);
    endtask

    task automatic t_sat;
        run_op("R4 byte sat neg", 2'b10, 1'b0, '1, {8{32'h8000_0000}},
               {32{8'hFF}}, {32{8'h80}});
        check32("R4 byte sat neg lane0", res_full[31:0], 32'h8000_0000);
        run_op("R4 word sat pos", 2'b11, 1'b0, '1, '0,
               {16{16'h8000}}, {16{16'h8000}});
        check32("R4 word sat pos lane0", res_full[31:0], 32'h7FFF_FFFF);
        run_op("R4 byte sat top", 2'b10, 1'b0, '1, {8{32'h7FFF_FFFF}},
               {32{8'hFF}}, {32{8'h7F}});
        check32("R4 byte sat top lane0", res_full[31:0], 32'h7FFF_FFFF);
        run_op("R4 word sat bottom", 2'b11, 1'b0, '1, {8{32'h8000_0000}},
               {16{16'h8000}}, {16{16'h7FFF}});
        check32("R4 word sat bottom lane0", res_full[31:0], 32'h8000_0000);
    endtask

    task automatic t_merge;
        run_op("R5 merge none", 2'b00, 1'b0, '0, {8{32'hDEAD_BEEF}},
               {32{8'h11}}, {32{8'h22}});
        check32("R5 merge lane3", res_full[127:96], 32'hDEAD_BEEF);
        run_op("R5 merge alt", 2'b01, 1'b0, 8'b1010_0101, {8{32'h1234_5678}},
               {16{16'h0102}}, {16{16'hFF03}});
    endtask

    task automatic t_zero;
        run_op("R6 zero none", 2'b10, 1'b1, '0, {8{32'hDEAD_BEEF}},
               {32{8'h11}}, {32{8'h22}});
        check32("R6 zero lane2", res_full[95:64], 32'h0);
        run_op("R6 zero all on", 2'b00, 1'b1, '1, {8{32'd7}},
               {32{8'd1}}, {32{8'd1}});
        check32("R6 all on lane0", res_full[31:0], 32'd11);
    endtask

    task automatic t_width;
        run_op("R7 width", 2'b00, 1'b0, '1, {8{32'hFFFF_0000}},
               {32{8'hAB}}, {32{8'hCD}});
        check32("R7 half lane4", res_half[159:128], 32'h0);
        check32("R7 half lane7", res_half[255:224], 32'h0);
    endtask

    task automatic t_timing;
        logic [VW-1:0] held;
        run_op("R8 capture", 2'b01, 1'b0, '1, {8{32'd42}},
               {16{16'd3}}, {16{16'd4}});
        held = res_full;
        @(negedge clk);
        acc_in = ~acc_in; src_a = ~src_a;
        @(negedge clk);
        check32("R8 out_valid drop", {31'b0, ov_full}, 32'd0);
        check_vec("R8 result hold", res_full, held);
    endtask

    task automatic t_random;
        for (int i = 0; i < 300; i++) begin
            logic [VW-1:0] s, a, b;
            for (int w = 0; w < NL; w++) begin
                s[32*w +: 32] = $urandom;
                a[32*w +: 32] = $urandom;
                b[32*w +: 32] = $urandom;
            end
            if (i % 7 == 0) s[31:0] = 32'h7FFF_FFF0;
            if (i % 11 == 0) s[63:32] = 32'h8000_0010;
            run_op("R1 R2 R3 R4 R5 R6 random", 2'($urandom), 1'($urandom),
                   NL'($urandom), s, a, b);
        end
    endtask

    initial begin
        #(8 * 150000);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        t_byte_basic();
        t_word_basic();
        t_wrap();
        t_sat();
        t_merge();
        t_zero();
        t_width();
        t_timing();
        t_random();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule